// File: doc/BRIEF.md
# Multi-Block Fetch Return Address Stack

This block predicts return targets for a fetch unit that brings in several basic blocks in one cycle. Every cycle the fetch unit may present a group of up to `NBLK` blocks. The first block starts at the PC and the start addresses of the blocks after it come from elsewhere in the predictor. For each block the group states how the block ends: a conditional branch, a call, a return, or an indirect jump. For each call it also gives the return address.

In a single cycle the stack pushes the return address of every call in the group, in block order. If the group closes with a return, it pops once and drives the popped address as the predicted next fetch address. That address may have been pushed by a call earlier in the same group. A return or an indirect jump closes the group, and any block listed after it is ignored. The stack is a circular buffer of `DEPTH` entries. Recovery after a misprediction is done by reloading the top-of-stack pointer from a checkpoint, which the fetch unit takes from the `top_ptr` output.

Top module: `mbf_ras`

## Requirements
- R1: Reset (active-low `rst_n`) clears every stack entry to zero and sets `top_ptr` to 0. A return seen before any call then predicts address 0.
- R2: Block i's end kind is `blk_kind[2i+1:2i]`, encoded 00 conditional, 01 call, 10 return, 11 indirect jump. Its return address is `blk_ret_addr[AW*i +: AW]`. Only blocks with i < `blk_cnt` take part.
- R3: All calls in an accepted group push in the same cycle and in block order, so the call with the highest index ends up on top. Later pops return the addresses in reverse push order.
- R4: `pred_valid` is 1 only in a cycle whose accepted group closes with a return. In that cycle `pred_addr` is the top entry after the group's pushes, and the entry is popped.
- R5: When a group contains calls followed by a closing return, `pred_addr` in that same cycle equals the return address of the last call in that group.
- R6: A block that lies after a return or an indirect jump in the same group is ignored. It neither pushes nor pops.
- R7: Pushing more than `DEPTH` addresses wraps around and overwrites the oldest entries. With DEPTH=8, after 9 pushes the pops return push 9 down to push 2, and the ninth pop returns push 9 again.
- R8: A pop on an empty stack does not fail. It returns the entry at the current pointer, and the pointer wraps downward (0 becomes DEPTH-1).
- R9: When `restore_en` is 1, `top_ptr` loads `restore_ptr` at the next edge. Any group presented in that cycle is ignored (no push, no pop, `pred_valid` 0), and stored entries keep their values.
- R10: With `grp_valid` 0 and no restore, `top_ptr` and the stored entries do not change, and `pred_valid` is 0.
- R11: After an accepted group, `top_ptr` equals the previous value plus the number of pushes minus the pop, modulo `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A fetch group is presented this cycle |
| blk_cnt | input | $clog2(NBLK+1) | Number of blocks in the group |
| blk_kind | input | 2*NBLK | End kind of each block, 2 bits per block |
| blk_ret_addr | input | AW*NBLK | Return address of each block (used for calls) |
| restore_en | input | 1 | Reload the top-of-stack pointer |
| restore_ptr | input | $clog2(DEPTH) | Checkpointed pointer value |
| pred_valid | output | 1 | A return target is predicted this cycle |
| pred_addr | output | AW | Predicted return target |
| top_ptr | output | $clog2(DEPTH) | Current top-of-stack pointer, used for checkpoints |

## Verification
The hardest state to reach from the ports is a stack whose ring has wrapped more than once, with the pointer in the middle of the buffer, followed by a restore that has to leave the overwritten entries intact. The bench gets there by first running a vector table that moves the pointer through underflow. It then pushes nine addresses in groups of four, four and one, and pops all nine to see the wrap-around order. Next it pushes two more entries and restores the pointer while a conflicting group is presented. Two pops afterwards show that the older wrapped entries survived the ignored group.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    END_COND = 2'b00,
    END_CALL = 2'b01,
    END_RET  = 2'b10,
    END_JUMP = 2'b11
  } end_kind_e;

  // Ring arithmetic: base moved up by 'up' and down by 'down', modulo depth.
  function automatic int unsigned ring_step(int unsigned base, int unsigned up,
                                            int unsigned down, int unsigned depth);
    return (base + up + depth - down) % depth;
  endfunction

endpackage

// File: rtl/ras_scan.sv
// Decodes a fetch group: which blocks push, their push rank, and the final pop.
module ras_scan
  import ras_pkg::*;
#(
  parameter int NBLK = 4,
  localparam int CW = $clog2(NBLK + 1),
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic                      take,
  input  logic [CW-1:0]             blk_cnt,
  input  logic [2*NBLK-1:0]         blk_kind,
  output logic [NBLK-1:0]           push_mask,
  output logic [NBLK-1:0][CW-1:0]   push_rank,
  output logic [CW-1:0]             push_cnt,
  output logic                      pop_req,
  output logic [IW-1:0]             last_idx
);

  logic      live;
  end_kind_e kind;

  always_comb begin
    live      = take;
    push_mask = '0;
    push_rank = '0;
    push_cnt  = '0;
    pop_req   = 1'b0;
    last_idx  = '0;
    kind      = END_COND;
    for (int i = 0; i < NBLK; i++) begin
      kind = end_kind_e'(blk_kind[2*i +: 2]);
      if (live && (i < int'(blk_cnt))) begin
        case (kind)
          END_CALL: begin
            push_cnt     = push_cnt + 1'b1;
            push_mask[i] = 1'b1;
            push_rank[i] = push_cnt;
            last_idx     = IW'(i);
          end
          END_RET: begin
            pop_req = 1'b1;
            live    = 1'b0;
          end
          END_JUMP: live = 1'b0;
          default: ;
        endcase
      end else begin
        live = 1'b0;
      end
    end
  end

endmodule

// File: rtl/ras_store.sv
// Circular entry storage with up to NBLK writes per cycle.
module ras_store
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NBLK  = 4,
  parameter int AW    = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(NBLK + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [PW-1:0]           base_ptr,
  input  logic [NBLK-1:0]         push_mask,
  input  logic [NBLK-1:0][CW-1:0] push_rank,
  input  logic [AW*NBLK-1:0]      push_data,
  input  logic [PW-1:0]           rd_ptr,
  output logic [AW-1:0]           rd_data
);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] slot [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_slot
    assign slot[g] = PW'(ring_step(int'(base_ptr), int'(push_rank[g]), 0, DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else if (commit) begin
      for (int b = 0; b < NBLK; b++) begin
        if (push_mask[b]) mem[slot[b]] <= push_data[AW*b +: AW];
      end
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/ras_tos.sv
// Top-of-stack pointer register with checkpoint reload.
module ras_tos
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NBLK  = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(NBLK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore_en,
  input  logic [PW-1:0] restore_ptr,
  input  logic          commit,
  input  logic [CW-1:0] push_cnt,
  input  logic          pop_req,
  output logic [PW-1:0] tos_q
);

  logic [PW-1:0] tos_next;

  assign tos_next = PW'(ring_step(int'(tos_q), int'(push_cnt), int'(pop_req), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n)          tos_q <= '0;
    else if (restore_en) tos_q <= restore_ptr;
    else if (commit)     tos_q <= tos_next;
  end

endmodule

// File: rtl/mbf_ras.sv
module mbf_ras
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NBLK  = 4,
  parameter int AW    = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(NBLK + 1),
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grp_valid,
  input  logic [CW-1:0]      blk_cnt,
  input  logic [2*NBLK-1:0]  blk_kind,
  input  logic [AW*NBLK-1:0] blk_ret_addr,
  input  logic               restore_en,
  input  logic [PW-1:0]      restore_ptr,
  output logic               pred_valid,
  output logic [AW-1:0]      pred_addr,
  output logic [PW-1:0]      top_ptr
);

  logic                    grp_take;
  logic [NBLK-1:0]         push_mask;
  logic [NBLK-1:0][CW-1:0] push_rank;
  logic [CW-1:0]           push_cnt;
  logic                    pop_req;
  logic [IW-1:0]           last_idx;
  logic [PW-1:0]           tos_q;
  logic [AW-1:0]           rd_data;

  assign grp_take = grp_valid && !restore_en;

  ras_scan #(.NBLK(NBLK)) u_scan (
    .take      (grp_take),
    .blk_cnt   (blk_cnt),
    .blk_kind  (blk_kind),
    .push_mask (push_mask),
    .push_rank (push_rank),
    .push_cnt  (push_cnt),
    .pop_req   (pop_req),
    .last_idx  (last_idx)
  );

  ras_store #(.DEPTH(DEPTH), .NBLK(NBLK), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (grp_take),
    .base_ptr  (tos_q),
    .push_mask (push_mask),
    .push_rank (push_rank),
    .push_data (blk_ret_addr),
    .rd_ptr    (tos_q),
    .rd_data   (rd_data)
  );

  ras_tos #(.DEPTH(DEPTH), .NBLK(NBLK)) u_tos (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore_en  (restore_en),
    .restore_ptr (restore_ptr),
    .commit      (grp_take),
    .push_cnt    (push_cnt),
    .pop_req     (pop_req),
    .tos_q       (tos_q)
  );

  // A pop after same-cycle pushes takes the last call's address directly.
  assign pred_valid = pop_req;
  assign pred_addr  = (push_cnt != '0) ? blk_ret_addr[int'(last_idx)*AW +: AW] : rd_data;
  assign top_ptr    = tos_q;

endmodule

// File: rtl/ras_chk.sv
module ras_chk
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NBLK  = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(NBLK + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grp_valid,
  input logic [CW-1:0] blk_cnt,
  input logic          restore_en,
  input logic [PW-1:0] restore_ptr,
  input logic          grp_take,
  input logic [CW-1:0] push_cnt,
  input logic          pop_req,
  input logic          pred_valid,
  input logic [PW-1:0] top_ptr
);

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> top_ptr == $past(restore_ptr)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_valid && !restore_en) |=> $stable(top_ptr)); // R10

  AST_PRED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> (grp_valid && !restore_en)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    grp_take |=> top_ptr == PW'(ring_step(int'($past(top_ptr)), int'($past(push_cnt)),
                                          int'($past(pop_req)), DEPTH))); // R11

  AST_PUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    grp_take |-> (push_cnt <= blk_cnt)); // R2

  AST_RESTORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |-> (!pop_req && push_cnt == '0)); // R9

endmodule

bind mbf_ras ras_chk #(.DEPTH(DEPTH), .NBLK(NBLK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grp_valid   (grp_valid),
  .blk_cnt     (blk_cnt),
  .restore_en  (restore_en),
  .restore_ptr (restore_ptr),
  .grp_take    (grp_take),
  .push_cnt    (push_cnt),
  .pop_req     (pop_req),
  .pred_valid  (pred_valid),
  .top_ptr     (top_ptr)
);

// File: tb/mbf_ras_tb.sv
module mbf_ras_tb;

  localparam int DEPTH = 8;
  localparam int NBLK  = 4;
  localparam int AW    = 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               grp_valid;
  logic [2:0]         blk_cnt;
  logic [7:0]         blk_kind;
  logic [AW*NBLK-1:0] blk_ret_addr;
  logic               restore_en;
  logic [2:0]         restore_ptr;
  logic               pred_valid;
  logic [AW-1:0]      pred_addr;
  logic [2:0]         top_ptr;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  mbf_ras #(.DEPTH(DEPTH), .NBLK(NBLK), .AW(AW)) u_dut (
    .clk (clk), .rst_n (rst_n), .grp_valid (grp_valid), .blk_cnt (blk_cnt),
    .blk_kind (blk_kind), .blk_ret_addr (blk_ret_addr), .restore_en (restore_en),
    .restore_ptr (restore_ptr), .pred_valid (pred_valid), .pred_addr (pred_addr),
    .top_ptr (top_ptr)
  );

  // kinds: 00 cond, 01 call, 10 return, 11 jump; block0 in bits [1:0]
  typedef struct packed {
    logic [2:0]  cnt;
    logic [7:0]  kind;
    logic [15:0] a3, a2, a1, a0;
    logic        pv;
    logic [15:0] pa;
    logic [2:0]  tos;
  } vec_t;

  localparam vec_t VTAB [12] = '{
    '{3'd4, 8'b00010001, 16'h0,   16'h200, 16'h0,   16'h100, 1'b0, 16'h0,   3'd2}, // R3 two calls
    '{3'd1, 8'b00000010, 16'h0,   16'h0,   16'h0,   16'h0,   1'b1, 16'h200, 3'd1}, // R4 pop
    '{3'd3, 8'b00100101, 16'h0,   16'h0,   16'h400, 16'h300, 1'b1, 16'h400, 3'd2}, // R5 same cycle
    '{3'd1, 8'b00000010, 16'h0,   16'h0,   16'h0,   16'h0,   1'b1, 16'h300, 3'd1}, // R3 order
    '{3'd4, 8'b10010111, 16'h0,   16'h0,   16'h500, 16'h0,   1'b0, 16'h0,   3'd1}, // R6 after jump
    '{3'd1, 8'b00000010, 16'h0,   16'h0,   16'h0,   16'h0,   1'b1, 16'h100, 3'd0}, // R6 untouched
    '{3'd2, 8'b00100101, 16'h0,   16'h0,   16'h700, 16'h600, 1'b0, 16'h0,   3'd2}, // R2 count limit
    '{3'd4, 8'b10000000, 16'h0,   16'h0,   16'h0,   16'h0,   1'b1, 16'h700, 3'd1}, // R4 return last
    '{3'd1, 8'b00000010, 16'h0,   16'h0,   16'h0,   16'h0,   1'b1, 16'h600, 3'd0}, // R11
    '{3'd1, 8'b00000010, 16'h0,   16'h0,   16'h0,   16'h0,   1'b1, 16'h0,   3'd7}, // R8 underflow
    '{3'd1, 8'b00000010, 16'h0,   16'h0,   16'h0,   16'h0,   1'b1, 16'h0,   3'd6}, // R8 again
    '{3'd2, 8'b00001001, 16'h0,   16'h0,   16'h0,   16'h800, 1'b1, 16'h800, 3'd6}  // R5
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Presents one cycle of stimulus; checks the prediction before the edge
  // and the pointer after it.
  task automatic step(input logic v, input logic rs, input logic [2:0] rp,
                      input logic [2:0] c, input logic [7:0] k,
                      input logic [31:0] x0, input logic [31:0] x1,
                      input logic [31:0] x2, input logic [31:0] x3,
                      input logic epv, input logic [31:0] epa,
                      input logic [2:0] etos, input string req);
    @(negedge clk);
    grp_valid    = v;
    restore_en   = rs;
    restore_ptr  = rp;
    blk_cnt      = c;
    blk_kind     = k;
    blk_ret_addr = {x3, x2, x1, x0};
    #1;
    check(pred_valid == epv, req, 32'(pred_valid), 32'(epv));
    if (epv) check(pred_addr == epa, req, pred_addr, epa);
    @(posedge clk);
    #1;
    check(top_ptr == etos, req, 32'(top_ptr), 32'(etos));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; grp_valid = 1'b0; restore_en = 1'b0; restore_ptr = '0;
    blk_cnt = '0; blk_kind = '0; blk_ret_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(top_ptr == 3'd0, "R1 reset pointer", 32'(top_ptr), 32'd0);
    check(pred_valid == 1'b0, "R1 reset pred", 32'(pred_valid), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'b0, 3'd0, VTAB[i].cnt, VTAB[i].kind, 32'(VTAB[i].a0), 32'(VTAB[i].a1),
           32'(VTAB[i].a2), 32'(VTAB[i].a3), VTAB[i].pv, 32'(VTAB[i].pa), VTAB[i].tos,
           $sformatf("vector %0d", i));
    end

    // R7: nine pushes in groups of 4, 4, 1 starting at pointer 6
    step(1'b1, 1'b0, 3'd0, 3'd4, 8'b01010101, 32'h901, 32'h902, 32'h903, 32'h904,
         1'b0, 32'h0, 3'd2, "R7 push 1-4");
    step(1'b1, 1'b0, 3'd0, 3'd4, 8'b01010101, 32'h905, 32'h906, 32'h907, 32'h908,
         1'b0, 32'h0, 3'd6, "R7 push 5-8");
    step(1'b1, 1'b0, 3'd0, 3'd1, 8'b00000001, 32'h909, 32'h0, 32'h0, 32'h0,
         1'b0, 32'h0, 3'd7, "R7 push 9");
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b0, 3'd0, 3'd1, 8'b00000010, 32'h0, 32'h0, 32'h0, 32'h0,
           1'b1, 32'h909 - 32'(k), 3'(7 - k - 1), "R7 wrapped pop");
    end
    step(1'b1, 1'b0, 3'd0, 3'd1, 8'b00000010, 32'h0, 32'h0, 32'h0, 32'h0,
         1'b1, 32'h909, 3'd6, "R7 ninth pop");

    // R9: push two, then restore to 6 while a group with call+return is shown
    step(1'b1, 1'b0, 3'd0, 3'd2, 8'b00000101, 32'ha01, 32'ha02, 32'h0, 32'h0,
         1'b0, 32'h0, 3'd0, "R9 pre-push");
    step(1'b1, 1'b1, 3'd6, 3'd2, 8'b00001001, 32'hb01, 32'h0, 32'h0, 32'h0,
         1'b0, 32'h0, 3'd6, "R9 restore");
    step(1'b1, 1'b0, 3'd0, 3'd1, 8'b00000010, 32'h0, 32'h0, 32'h0, 32'h0,
         1'b1, 32'h908, 3'd5, "R9 entry kept");
    step(1'b1, 1'b0, 3'd0, 3'd1, 8'b00000010, 32'h0, 32'h0, 32'h0, 32'h0,
         1'b1, 32'h907, 3'd4, "R9 entry kept 2");

    // R10: idle cycle with a return pattern on the inputs
    step(1'b0, 1'b0, 3'd0, 3'd1, 8'b00000010, 32'h0, 32'h0, 32'h0, 32'h0,
         1'b0, 32'h0, 3'd4, "R10 idle");
    step(1'b1, 1'b0, 3'd0, 3'd1, 8'b00000010, 32'h0, 32'h0, 32'h0, 32'h0,
         1'b1, 32'h906, 3'd3, "R10 content kept");

    // R1: reset in mid-run clears pointer and entries
    @(negedge clk);
    rst_n = 1'b0; grp_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(top_ptr == 3'd0, "R1 mid-run reset", 32'(top_ptr), 32'd0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 3'd0, 3'd1, 8'b00000010, 32'h0, 32'h0, 32'h0, 32'h0,
         1'b1, 32'h0, 3'd7, "R1 cleared entry");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule